// File: doc/BRIEF.md
# Dual-Mode Serial Conversion-Word Transmitter

This block sends one finished conversion word over a three-wire serial link, most significant bit first. A word is placed in a holding register by a load strobe. An active-low ready flag then announces that a word is waiting. Once the chip select has been synchronised and seen low while the flag is low, the word is copied into a shift register and streamed out. Loads that arrive while a transfer is running are dropped.

The mode input is sampled when a transfer starts and picks one of two modes. In master mode the block makes its own serial clock from the system clock, with one system clock per phase. In slave mode the block follows an external serial clock, which it synchronises and edge-detects in the system clock domain. Raising chip select early lets the bit on the line finish, then releases the link. The word is kept, so the next selection sends it again from the top.

Top module: `conv_serial_tx`

## Requirements
- R1: In master mode each high phase of `sclkOut` lasts exactly one system clock, and so does each low phase.
- R2: In master mode, with chip select already low, `sdoOe` rises and `sdo` carries the MSB two system clocks after `readyN` falls. The first rising edge of `sclkOut` follows one system clock later.
- R3: In master mode the word leaves MSB first (bit WORD_W-1 first). The next bit appears on `sdo` at each falling edge of `sclkOut`.
- R4: In master mode, `sdoOe` and `sclkOe` drop two system clocks after the final rising edge of `sclkOut`. `readyN` returns high on that same clock.
- R5: In slave mode, `sdoOe` rises with the MSB one system clock after the start is accepted, and `sclkOe` stays low. `sdo` moves to the next bit only on a falling edge of `sclkIn`, at most four system clocks after that edge. After the WORD_W-th falling edge, `sdoOe` drops and `readyN` returns high.
- R6: In slave mode, falling edges of `sclkIn` that come before the first rising edge of the transfer leave `sdo` unchanged.
- R7: If chip select rises during a transfer, the current bit is completed. Master mode finishes the high phase in progress, one low clock follows, and then both enables drop. Slave mode drops the enable at the next falling edge of `sclkIn`. `readyN` stays low, and the next selection sends the full held word from the MSB.
- R8: `csN` passes through a two-flop synchroniser, so a transfer starts two system clocks after `csN` falls. No transfer starts while `readyN` is high.
- R9: `readyN` goes low one clock after `loadStb` in idle. A `loadStb` during a transfer changes neither the word being sent nor `readyN`.
- R10: After reset, and whenever no transfer is running, `sdoOe` and `sclkOe` are low. `readyN` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | 1 selects master mode, 0 selects slave mode; sampled at transfer start |
| csN | input | 1 | Active-low chip select, asynchronous |
| loadData | input | WORD_W | Conversion word to hold |
| loadStb | input | 1 | Captures `loadData` when idle |
| sclkIn | input | 1 | External serial clock for slave mode |
| sdo | output | 1 | Serial data |
| sdoOe | output | 1 | Output enable for `sdo` |
| sclkOut | output | 1 | Generated serial clock in master mode |
| sclkOe | output | 1 | Output enable for `sclkOut` |
| readyN | output | 1 | Active-low word-ready flag |

## Verification
The bench builds the block with WORD_W set to 12 instead of the default 20. Full master and slave transfers, and the walk to the final bit, then take only a few hundred cycles, so many random words and modes fit in one run. With this width an early chip-select release can be placed partway through the word, and the resend from the MSB can still be checked bit by bit. The bench paces the external serial clock at four system clocks per phase, which meets the minimum ratio set by the synchroniser.

// File: rtl/cst_pkg.sv
package cst_pkg;

  typedef struct packed {
    logic loadHold;
    logic copyShift;
    logic shiftOne;
  } cst_strobe_t;

  typedef enum logic [2:0] {
    CST_IDLE,
    CST_ARM,
    CST_MLOW,
    CST_MHIGH,
    CST_TAIL,
    CST_WAITR,
    CST_SSHIFT
  } cst_state_t;

endpackage

// File: rtl/cst_sync.sv
module cst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cst_dpath.sv
module cst_dpath
  import cst_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  cst_strobe_t       strb,
  input  logic [WORD_W-1:0] loadData,
  output logic              sdo
);
  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (strb.loadHold) holdReg <= loadData;
      if (strb.copyShift)     shiftReg <= holdReg;
      else if (strb.shiftOne) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo = shiftReg[WORD_W-1];

  // R9: a load, a copy and a shift never share a cycle
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadHold, strb.copyShift, strb.shiftOne}));
endmodule

// File: rtl/cst_ctrl.sv
module cst_ctrl
  import cst_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        masterMode,
  input  logic        csN,
  input  logic        loadStb,
  input  logic        sclkIn,
  output cst_strobe_t strb,
  output logic        sdoOe,
  output logic        sclkOut,
  output logic        sclkOe,
  output logic        readyN
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic csSync, sclkSync, sclkPrev, sclkRise, sclkFall;
  logic abortReq, finished, lastBit, stopNow;
  logic [CNT_W-1:0] bitCnt;
  cst_state_t st, stNxt;

  cst_sync #(.STAGES(2), .RST_VAL(1'b1)) csSync_i (
    .clk(clk), .rstN(rstN), .d(csN), .q(csSync));
  cst_sync #(.STAGES(2), .RST_VAL(1'b0)) sclkSync_i (
    .clk(clk), .rstN(rstN), .d(sclkIn), .q(sclkSync));

  assign sclkRise = sclkSync & ~sclkPrev;
  assign sclkFall = ~sclkSync & sclkPrev;
  assign lastBit  = (bitCnt == LAST_IDX);
  assign stopNow  = lastBit | abortReq | csSync;

  always_comb begin
    stNxt         = st;
    strb          = '0;
    strb.loadHold = loadStb && (st == CST_IDLE);
    unique case (st)
      CST_IDLE:
        if (!csSync && !readyN && !loadStb) begin
          strb.copyShift = 1'b1;
          stNxt = masterMode ? CST_ARM : CST_WAITR;
        end
      CST_ARM:   stNxt = csSync ? CST_IDLE : CST_MLOW;
      CST_MLOW:  stNxt = CST_MHIGH;
      CST_MHIGH:
        if (stopNow) stNxt = CST_TAIL;
        else begin
          strb.shiftOne = 1'b1;
          stNxt = CST_MLOW;
        end
      CST_TAIL:  stNxt = CST_IDLE;
      CST_WAITR:
        if (csSync)        stNxt = CST_IDLE;
        else if (sclkRise) stNxt = CST_SSHIFT;
      CST_SSHIFT:
        if (sclkFall) begin
          if (stopNow) stNxt = CST_IDLE;
          else         strb.shiftOne = 1'b1;
        end
      default:   stNxt = CST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= CST_IDLE;
      bitCnt   <= '0;
      abortReq <= 1'b0;
      finished <= 1'b0;
      readyN   <= 1'b1;
      sdoOe    <= 1'b0;
      sclkOe   <= 1'b0;
      sclkOut  <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      st       <= stNxt;
      sclkPrev <= sclkSync;
      if (strb.copyShift)     bitCnt <= '0;
      else if (strb.shiftOne) bitCnt <= bitCnt + 1'b1;
      if (st == CST_IDLE)     abortReq <= 1'b0;
      else if (csSync)        abortReq <= 1'b1;
      if (st == CST_MHIGH && stNxt == CST_TAIL) finished <= lastBit;
      if (strb.loadHold) readyN <= 1'b0;
      else if ((st == CST_TAIL && finished) ||
               (st == CST_SSHIFT && sclkFall && lastBit)) readyN <= 1'b1;
      sdoOe   <= (stNxt != CST_IDLE) && (stNxt != CST_ARM);
      sclkOe  <= (stNxt == CST_MLOW) || (stNxt == CST_MHIGH) || (stNxt == CST_TAIL);
      sclkOut <= (stNxt == CST_MHIGH);
    end
  end

  // R1: a generated high phase lasts a single system clock
  p_sclk_high_one_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOe && sclkOut) |=> !sclkOut);

  // R10: no drive on either line while idle
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st == CST_IDLE) |-> (!sdoOe && !sclkOe));

  // R8: an idle port with the ready flag high stays idle
  p_no_start_unready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st == CST_IDLE && readyN) |=> (st == CST_IDLE));

  // R4: ready returns high together with the data release
  p_ready_with_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyN) |-> (!sdoOe && $past(sdoOe)));

  // R5: the clock line is never driven in slave mode
  p_slave_no_sclk_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == CST_WAITR || st == CST_SSHIFT) |-> !sclkOe);
endmodule

// File: rtl/conv_serial_tx.sv
module conv_serial_tx
  import cst_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              csN,
  input  logic [WORD_W-1:0] loadData,
  input  logic              loadStb,
  input  logic              sclkIn,
  output logic              sdo,
  output logic              sdoOe,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              readyN
);
  cst_strobe_t strb;

  cst_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .csN(csN),
    .loadStb(loadStb), .sclkIn(sclkIn), .strb(strb), .sdoOe(sdoOe),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .readyN(readyN));

  cst_dpath #(.WORD_W(WORD_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadData(loadData), .sdo(sdo));
endmodule

// File: tb/conv_serial_tx_tb_top.sv
module conv_serial_tx_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic csN = 1'b1;
  logic [W-1:0] loadData = '0;
  logic loadStb = 1'b0;
  logic sclkIn = 1'b1;
  logic sdo, sdoOe, sclkOut, sclkOe, readyN;
  int checks = 0;
  int errors = 0;
  bit finishedRun = 1'b0;

  always #5 clk = ~clk;

  conv_serial_tx #(.WORD_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .csN(csN),
    .loadData(loadData), .loadStb(loadStb), .sclkIn(sclkIn), .sdo(sdo),
    .sdoOe(sdoOe), .sclkOut(sclkOut), .sclkOe(sclkOe), .readyN(readyN));

  function automatic logic bitOf(input logic [W-1:0] word, input int i);
    return word[W-1-i];
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wait4();
    repeat (4) tick();
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [W-1:0] word);
    loadData = word;
    loadStb  = 1'b1;
    tick();
    loadStb  = 1'b0;
    chk("R9 ready low after load", 32'(readyN), 32'd0);
  endtask

  // Starts just before the edge that accepts the start in master mode.
  task automatic masterStream(input logic [W-1:0] word, input int abortAt, input bit injectLoad);
    tick();
    chk("R2 no data before two clocks", 32'(sdoOe), 32'd0);
    for (int i = 0; i < W; i++) begin
      tick();
      loadStb = 1'b0;
      chk("R1 low phase", 32'(sclkOut), 32'd0);
      chk("R3 bit order", 32'(sdo), 32'(bitOf(word, i)));
      chk("R2 data enabled", 32'(sdoOe), 32'd1);
      if (i == abortAt) begin
        csN = 1'b1;
        tick(); chk("R7 bit in progress high", 32'(sclkOut), 32'd1);
        chk("R7 bit in progress data", 32'(sdo), 32'(bitOf(word, i)));
        tick(); chk("R7 next bit begins", 32'(sdo), 32'(bitOf(word, i + 1)));
        tick(); chk("R7 bit completes high", 32'(sclkOut), 32'd1);
        tick(); chk("R7 tail low", 32'(sclkOut), 32'd0);
        chk("R7 still driven in tail", 32'(sdoOe), 32'd1);
        tick(); chk("R7 data released", 32'(sdoOe), 32'd0);
        chk("R7 clock released", 32'(sclkOe), 32'd0);
        chk("R7 ready stays low", 32'(readyN), 32'd0);
        return;
      end
      tick();
      chk("R1 high phase", 32'(sclkOut), 32'd1);
      chk("R3 bit held in high", 32'(sdo), 32'(bitOf(word, i)));
      if (injectLoad && i == 2) begin
        loadData = ~word;
        loadStb  = 1'b1;
      end
    end
    tick();
    chk("R4 tail clock low", 32'(sclkOut), 32'd0);
    chk("R4 tail still driven", 32'(sdoOe), 32'd1);
    tick();
    chk("R4 data released", 32'(sdoOe), 32'd0);
    chk("R4 clock released", 32'(sclkOe), 32'd0);
    chk("R4 ready high", 32'(readyN), 32'd1);
  endtask

  // Starts just before the edge that accepts the start in slave mode.
  task automatic slaveStream(input logic [W-1:0] word, input int abortAt);
    tick();
    chk("R5 data enabled at start", 32'(sdoOe), 32'd1);
    chk("R5 clock not driven", 32'(sclkOe), 32'd0);
    chk("R5 MSB first", 32'(sdo), 32'(bitOf(word, 0)));
    sclkIn = 1'b0; wait4();
    chk("R6 early fall ignored", 32'(sdo), 32'(bitOf(word, 0)));
    sclkIn = 1'b1; wait4();
    for (int i = 0; i < W; i++) begin
      chk("R5 slave bit", 32'(sdo), 32'(bitOf(word, i)));
      chk("R5 slave enabled", 32'(sdoOe), 32'd1);
      if (i == abortAt) begin
        csN = 1'b1; wait4();
        chk("R7 slave holds bit", 32'(sdoOe), 32'd1);
        sclkIn = 1'b0; wait4();
        chk("R7 slave released", 32'(sdoOe), 32'd0);
        chk("R7 slave ready low", 32'(readyN), 32'd0);
        sclkIn = 1'b1; wait4();
        return;
      end
      sclkIn = 1'b0; wait4();
      sclkIn = 1'b1; wait4();
    end
    chk("R5 slave released", 32'(sdoOe), 32'd0);
    chk("R5 slave ready high", 32'(readyN), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finishedRun) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    void'($urandom(32'd1234));
    repeat (3) tick();
    chk("R10 reset ready", 32'(readyN), 32'd1);
    chk("R10 reset data off", 32'(sdoOe), 32'd0);
    chk("R10 reset clock off", 32'(sclkOe), 32'd0);
    rstN = 1'b1;
    tick();

    // R8: selection with nothing loaded starts nothing
    csN = 1'b0;
    repeat (10) tick();
    chk("R8 no start while ready high", 32'(sdoOe), 32'd0);
    chk("R10 idle clock off", 32'(sclkOe), 32'd0);

    // Master, select already low, load during transfer ignored
    masterMode = 1'b1;
    w = 12'hA5C;
    doLoad(w);
    masterStream(w, -1, 1'b1);
    chk("R9 late load left ready high", 32'(readyN), 32'd1);

    // Load with select high, then select: two-clock synchroniser
    csN = 1'b1; tick(); tick();
    w = 12'h3F1;
    doLoad(w);
    repeat (4) tick();
    chk("R8 held off by select", 32'(sdoOe), 32'd0);
    csN = 1'b0; tick(); tick();
    masterStream(w, -1, 1'b0);

    // Master early release, then full resend
    w = 12'hC93;
    doLoad(w);
    masterStream(w, 4, 1'b0);
    csN = 1'b0; tick(); tick();
    masterStream(w, -1, 1'b0);

    // Slave transfer
    masterMode = 1'b0;
    w = 12'h5B6;
    doLoad(w);
    slaveStream(w, -1);

    // Slave early release, resend in master mode
    w = 12'h817;
    doLoad(w);
    slaveStream(w, 3);
    masterMode = 1'b1;
    csN = 1'b0; tick(); tick();
    masterStream(w, -1, 1'b0);

    // Random words and modes
    for (int n = 0; n < 8; n++) begin
      w = W'($urandom);
      masterMode = 1'($urandom);
      tick();
      doLoad(w);
      if (masterMode) masterStream(w, -1, 1'b0);
      else            slaveStream(w, -1);
    end

    finishedRun = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule